// File: doc/BRIEF.md
# Burst Address Counter Register

This block holds the address that one memory port uses on each clock. On every rising edge it does one of four things: it clears the address to zero, takes a fresh address from outside, keeps the address it already has, or steps that address up by one. This lets a bus master give one start address and then stream through consecutive locations without driving the address lines again.

Three active-low controls pick the action, in a fixed order of precedence. The clear input comes first. The strobe that loads an outside address comes second. The count enable comes last and chooses between stepping and holding. The strobe does not depend on any chip-select logic. The output is the registered address that applies in the current cycle, together with a one-cycle flag raised when a step rolls the address over from all ones to zero.

Top module: `burst_addr_ctr`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first controlling edge, `cur_addr` is 0 and `wrap_pulse` is 0.
- R2: If `ctr_clr_n` is 0 at a rising edge, `cur_addr` becomes 0 after that edge, whatever `strobe_n`, `count_en_n` and `ext_addr` are.
- R3: If `ctr_clr_n` is 1 and `strobe_n` is 0 at a rising edge, `cur_addr` becomes the `ext_addr` sampled at that edge, whatever `count_en_n` is.
- R4: If `ctr_clr_n`, `strobe_n` and `count_en_n` are all 1 at a rising edge, `cur_addr` keeps its previous value and `ext_addr` has no effect.
- R5: If `ctr_clr_n` and `strobe_n` are 1 and `count_en_n` is 0 at a rising edge, `cur_addr` becomes its previous value plus one.
- R6: A step from 0xFFFF gives 0x0000, and `wrap_pulse` is 1 for exactly the one cycle after that edge. It is 0 after every other edge.
- R7: The controls and `ext_addr` act only at the rising edge. Changes between edges do not change `cur_addr`.
- R8: With the default parameter the address is 16 bits wide, and every bit of `ext_addr` reaches `cur_addr` on a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| ctr_clr_n | input | 1 | Synchronous clear of the address to 0, active low, highest precedence |
| strobe_n | input | 1 | Load strobe for the outside address, active low |
| count_en_n | input | 1 | Step enable, active low; when high the address is held |
| ext_addr | input | AW (16) | Address offered from outside |
| cur_addr | output | AW (16) | Address used in the current cycle |
| wrap_pulse | output | 1 | One-cycle flag after a rollover from all ones to zero |

## Verification
The bench drives clear, load and step together to check the order of precedence. If that order were wrong, a clear asserted together with a strobe would load the outside address instead of zero, or a load would be turned into a step. It drives a changing `ext_addr` while the counter is held, to catch a design that lets the outside address through when the strobe is high. It walks the address across 0xFFFF, where a counter with the wrong width or a misplaced flag would miss the rollover or flag it on the wrong cycle. It also pulses the strobe between edges, to catch logic that is sensitive to level changes rather than to the clock edge.

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctr_clr_n,
  input  logic          strobe_n,
  input  logic          count_en_n,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] cur_addr,
  output logic          wrap_pulse
);

  logic [AW-1:0] addr_q;
  logic          wrap_q;

  wire do_inc = ctr_clr_n & strobe_n & ~count_en_n;
  wire at_top = &addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= 1'b0;
      if (!ctr_clr_n)
        addr_q <= '0;
      else if (!strobe_n)
        addr_q <= ext_addr;
      else if (!count_en_n) begin
        addr_q <= addr_q + AW'(1);
        wrap_q <= at_top;
      end
    end
  end

  assign cur_addr   = addr_q;
  assign wrap_pulse = wrap_q;

  a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    !ctr_clr_n |=> cur_addr == '0);

  a_r3_load_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_clr_n && !strobe_n) |=> cur_addr == $past(ext_addr));

  a_r4_hold_prev: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_clr_n && strobe_n && count_en_n) |=> $stable(cur_addr));

  a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_clr_n && strobe_n && !count_en_n) |=> cur_addr == $past(cur_addr) + AW'(1));

  a_r6_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (do_inc && at_top) |=> (wrap_pulse && cur_addr == '0));

  a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |=> !wrap_pulse);

endmodule

// File: tb/tb_burst_addr_ctr.sv
module tb_burst_addr_ctr;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctr_clr_n = 1'b1;
  logic          strobe_n = 1'b1;
  logic          count_en_n = 1'b1;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] cur_addr;
  logic          wrap_pulse;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_ctr #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .ctr_clr_n(ctr_clr_n), .strobe_n(strobe_n),
    .count_en_n(count_en_n), .ext_addr(ext_addr),
    .cur_addr(cur_addr), .wrap_pulse(wrap_pulse)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cyc(logic clr, logic stb, logic cen, logic [AW-1:0] a);
    @(negedge clk);
    ctr_clr_n = clr; strobe_n = stb; count_en_n = cen; ext_addr = a;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 addr in reset", 32'(cur_addr), 0);
    chk("R1 wrap in reset", 32'(wrap_pulse), 0);
    @(negedge clk); rst_n = 1'b1;
    cyc(1, 1, 1, 16'h1234);
    chk("R1 addr after release", 32'(cur_addr), 0);
    chk("R1 wrap after release", 32'(wrap_pulse), 0);
  endtask

  task automatic t_load();
    cyc(1, 0, 1, 16'h0ABC);
    chk("R3 load cen high", 32'(cur_addr), 32'h0ABC);
    cyc(1, 0, 0, 16'h4321);
    chk("R3 load beats step", 32'(cur_addr), 32'h4321);
    cyc(1, 0, 1, 16'hA5C3);
    chk("R8 all bits", 32'(cur_addr), 32'hA5C3);
    cyc(1, 0, 1, 16'h5A3C);
    chk("R8 all bits inv", 32'(cur_addr), 32'h5A3C);
    chk("R8 width", $bits(cur_addr), 16);
  endtask

  task automatic t_clear();
    cyc(0, 0, 0, 16'hBEEF);
    chk("R2 clear beats load/step", 32'(cur_addr), 0);
    cyc(1, 0, 1, 16'h0077);
    cyc(0, 1, 1, 16'h1111);
    chk("R2 clear from 77", 32'(cur_addr), 0);
  endtask

  task automatic t_hold();
    cyc(1, 0, 1, 16'h0300);
    cyc(1, 1, 1, 16'hFFFF);
    chk("R4 hold ignores ext", 32'(cur_addr), 32'h0300);
    cyc(1, 1, 1, 16'h0001);
    chk("R4 hold again", 32'(cur_addr), 32'h0300);
  endtask

  task automatic t_step();
    cyc(1, 0, 1, 16'h00FE);
    for (int i = 1; i <= 4; i++) begin
      cyc(1, 1, 0, 16'h7777);
      chk("R5 step", 32'(cur_addr), 32'h00FE + i);
      chk("R6 no wrap on step", 32'(wrap_pulse), 0);
    end
  endtask

  task automatic t_wrap();
    cyc(1, 0, 1, 16'hFFFE);
    cyc(1, 1, 0, 16'h0);
    chk("R6 at top", 32'(cur_addr), 32'hFFFF);
    chk("R6 no flag yet", 32'(wrap_pulse), 0);
    cyc(1, 1, 0, 16'h0);
    chk("R6 rolled over", 32'(cur_addr), 0);
    chk("R6 flag set", 32'(wrap_pulse), 1);
    cyc(1, 1, 0, 16'h0);
    chk("R6 after rollover", 32'(cur_addr), 1);
    chk("R6 flag one cycle", 32'(wrap_pulse), 0);
    cyc(1, 0, 1, 16'hFFFF);
    cyc(1, 1, 1, 16'h0);
    chk("R6 hold at top no flag", 32'(wrap_pulse), 0);
  endtask

  task automatic t_edge_only();
    cyc(1, 0, 1, 16'h0420);
    cyc(1, 1, 1, 16'h0420);
    #0.5;
    strobe_n = 1'b0; ctr_clr_n = 1'b0; ext_addr = 16'hDEAD;
    #0.5;
    chk("R7 mid-cycle no effect", 32'(cur_addr), 32'h0420);
    strobe_n = 1'b1; ctr_clr_n = 1'b1; ext_addr = 16'h0;
    @(posedge clk); #1;
    chk("R7 glitch ignored", 32'(cur_addr), 32'h0420);
  endtask

  initial begin
    t_reset();
    t_load();
    t_clear();
    t_hold();
    t_step();
    t_wrap();
    t_edge_only();
    if (!done) begin
      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #20000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule